// File: doc/BRIEF.md
# Offset-Indexed Cache with Parallel Translation

This block is a read-only 4 KB direct-mapped cache that sits between a processor's load path and a simple word-wide memory port. The cache set is chosen purely from bits that lie inside the 4 KB page, so the tag/data array can be read in the same cycle that an eight-entry fully associative translation buffer converts the 20-bit virtual page number into a physical page number. The stored tag is the physical page number, and the lookup hits only when that tag matches the translation output and the line is valid.

A requester raises `req_i` with a 32-bit virtual address and holds both until `done_o` pulses. A hit answers after one clock edge. A cache miss with a good translation issues one word read at the physical address, fills the line and then answers. A translation miss raises `tlb_miss_o` and issues no memory traffic; translations are installed through a load port that replaces entries in round-robin order. A byte mode returns one zero-extended byte picked by the two low address bits instead of the whole word.

Top module: `offset_indexed_cache`

## Requirements
- R1: The virtual address splits as page number = bits [31:12], line index = bits [11:2], byte displacement = bits [1:0]; a fill read goes to `mem_addr_o` = {physical page, index, 2'b00}.
- R2: The translation buffer has 8 fully associative entries; each pulse of `tlb_ld_i` writes the next entry in round-robin order starting at entry 0 after reset, so the ninth load evicts the first one loaded.
- R3: When the page number matches no valid entry, `tlb_miss_o` is 1 in the cycle after the lookup edge, and neither `done_o` nor `mem_req_o` is raised for that request.
- R4: A lookup with a translation hit, a valid line and a stored tag equal to the translated page answers after one edge with `done_o`, `cache_hit_o` and `tlb_hit_o` all 1; `cache_hit_o` is never 1 without `tlb_hit_o`.
- R5: Tags are physical: two virtual pages translated to the same physical page share cached lines, so a line filled through one hits through the other.
- R6: Two physical pages with the same index conflict: the second access misses and replaces the line, after which the first misses again.
- R7: On a cache miss with a translation hit, `mem_req_o` rises one edge after the lookup and holds with a stable address until `mem_valid_i` is sampled 1; on the next edge `done_o` is 1 with `cache_hit_o` 0, `tlb_hit_o` 1 and the returned data, and the line is written.
- R8: With `byte_mode_i` 1, `rdata_o` = {24'b0, word[8d+7:8d]} for displacement d; with it 0, `rdata_o` is the whole aligned word.
- R9: Reset clears every line valid bit and every translation entry; outputs `done_o`, `mem_req_o` and `tlb_miss_o` read 0 during reset.
- R10: `done_o` is a one-cycle pulse; the requester drops `req_i` in the cycle `done_o` is high, and no second answer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request, held until done |
| vaddr_i | input | 32 | Virtual address |
| byte_mode_i | input | 1 | 1 selects a single zero-extended byte |
| tlb_ld_i | input | 1 | Install one translation |
| tlb_ld_vpn_i | input | 20 | Virtual page of the installed translation |
| tlb_ld_ppn_i | input | 20 | Physical page of the installed translation |
| mem_req_o | output | 1 | Fill read request |
| mem_addr_o | output | 32 | Fill word address (physical) |
| mem_valid_i | input | 1 | Fill data valid |
| mem_rdata_i | input | 32 | Fill data |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | 32 | Read result, valid with done_o |
| tlb_hit_o | output | 1 | Translation hit, valid with done_o |
| cache_hit_o | output | 1 | Cache hit, valid with done_o |
| tlb_miss_o | output | 1 | Translation miss seen on the last lookup |

## Verification
A hit is due exactly one edge after the request is first seen, a translation miss shows `tlb_miss_o` after that same single edge, and a cache miss shows `mem_req_o` after one edge and `done_o` one edge after the cycle `mem_valid_i` is sampled high. The bench keeps a behavioural model of the translation entries, round-robin pointer and line valid/tag state, predicts which of the three paths each access takes, and then checks every output at each falling edge along that path, including every wait cycle of a fill with varied memory latency. The cycle after each answer is also checked so that a lingering or repeated `done_o` is caught.

// File: rtl/oic_pkg.sv
package oic_pkg;
  localparam int unsigned VA_W    = 32;
  localparam int unsigned DISP_W  = 2;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned OFF_W   = IDX_W + DISP_W;
  localparam int unsigned VPN_W   = VA_W - OFF_W;
  localparam int unsigned PPN_W   = 20;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned TLB_N   = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RESP = 2'd2
  } oic_state_e;
endpackage

// File: rtl/oic_tlb.sv
module oic_tlb #(
  parameter int unsigned N     = 8,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  input  logic             ld_i,
  input  logic [VPN_W-1:0] ld_vpn_i,
  input  logic [PPN_W-1:0] ld_ppn_i
);
  localparam int unsigned PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     ent_v_q;
  logic [VPN_W-1:0] ent_vpn_q [N];
  logic [PPN_W-1:0] ent_ppn_q [N];
  logic [PTR_W-1:0] ptr_q;
  logic [N-1:0]     match;

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign match[g] = ent_v_q[g] && (ent_vpn_q[g] == lk_vpn_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_v_q[g]   <= 1'b0;
        ent_vpn_q[g] <= '0;
        ent_ppn_q[g] <= '0;
      end else if (ld_i && (ptr_q == PTR_W'(g))) begin
        ent_v_q[g]   <= 1'b1;
        ent_vpn_q[g] <= ld_vpn_i;
        ent_ppn_q[g] <= ld_ppn_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ld_i) begin
      ptr_q <= (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // one-hot select; loads never duplicate a page
  always_comb begin
    ppn_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) ppn_o = ppn_o | ent_ppn_q[i];
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/oic_array.sv
module oic_array #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (wr_i) begin
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/oic_ctrl.sv
module oic_ctrl
  import oic_pkg::*;
#(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DISP_W = 2,
  parameter int unsigned PPN_W  = 20,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              byte_mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              tlb_hit_i,
  input  logic [PPN_W-1:0]  ppn_i,
  input  logic              line_hit_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              wr_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [PPN_W-1:0]  wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              mem_req_o,
  output logic [PPN_W+IDX_W+DISP_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tlb_hit_o,
  output logic              cache_hit_o,
  output logic              tlb_miss_o
);
  oic_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [DISP_W-1:0] disp_q;
  logic              bm_q;
  logic              lookup;

  function automatic logic [DATA_W-1:0] fmt(input logic [DATA_W-1:0] w,
                                             input logic [DISP_W-1:0] d,
                                             input logic bm);
    logic [DATA_W-1:0] sh;
    sh = w >> {d, 3'b000};
    return bm ? {{(DATA_W-8){1'b0}}, sh[7:0]} : w;
  endfunction

  assign lookup = (state_q == ST_IDLE) && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      ppn_q       <= '0;
      disp_q      <= '0;
      bm_q        <= 1'b0;
      mem_req_o   <= 1'b0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
      tlb_hit_o   <= 1'b0;
      cache_hit_o <= 1'b0;
      tlb_miss_o  <= 1'b0;
    end else begin
      tlb_miss_o <= lookup && !tlb_hit_i;
      unique case (state_q)
        ST_IDLE: begin
          if (lookup && tlb_hit_i) begin
            idx_q  <= idx_i;
            ppn_q  <= ppn_i;
            disp_q <= disp_i;
            bm_q   <= byte_mode_i;
            if (line_hit_i) begin
              rdata_o     <= fmt(line_data_i, disp_i, byte_mode_i);
              done_o      <= 1'b1;
              tlb_hit_o   <= 1'b1;
              cache_hit_o <= 1'b1;
              state_q     <= ST_RESP;
            end else begin
              mem_req_o <= 1'b1;
              state_q   <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (mem_valid_i) begin
            mem_req_o   <= 1'b0;
            rdata_o     <= fmt(mem_rdata_i, disp_q, bm_q);
            done_o      <= 1'b1;
            tlb_hit_o   <= 1'b1;
            cache_hit_o <= 1'b0;
            state_q     <= ST_RESP;
          end
        end
        ST_RESP: begin
          done_o      <= 1'b0;
          tlb_hit_o   <= 1'b0;
          cache_hit_o <= 1'b0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o = {ppn_q, idx_q, {DISP_W{1'b0}}};
  assign wr_o       = (state_q == ST_FILL) && mem_valid_i;
  assign wr_idx_o   = idx_q;
  assign wr_tag_o   = ppn_q;
  assign wr_data_o  = mem_rdata_i;
endmodule

// File: rtl/offset_indexed_cache.sv
module offset_indexed_cache
  import oic_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [31:0] vaddr_i,
  input  logic        byte_mode_i,
  input  logic        tlb_ld_i,
  input  logic [19:0] tlb_ld_vpn_i,
  input  logic [19:0] tlb_ld_ppn_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_valid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        done_o,
  output logic [31:0] rdata_o,
  output logic        tlb_hit_o,
  output logic        cache_hit_o,
  output logic        tlb_miss_o
);
  logic [VPN_W-1:0]  vpn;
  logic [IDX_W-1:0]  idx;
  logic [DISP_W-1:0] disp;
  logic              tlb_hit;
  logic [PPN_W-1:0]  tlb_ppn;
  logic              line_v;
  logic [PPN_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              line_hit;
  logic              wr;
  logic [IDX_W-1:0]  wr_idx;
  logic [PPN_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;

  assign vpn  = vaddr_i[VA_W-1:OFF_W];
  assign idx  = vaddr_i[OFF_W-1:DISP_W];
  assign disp = vaddr_i[DISP_W-1:0];

  // translation and array read run side by side on disjoint address bits
  oic_tlb #(.N(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_tlb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_vpn_i (vpn),
    .hit_o    (tlb_hit),
    .ppn_o    (tlb_ppn),
    .ld_i     (tlb_ld_i),
    .ld_vpn_i (tlb_ld_vpn_i),
    .ld_ppn_i (tlb_ld_ppn_i)
  );

  oic_array #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)) i_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (idx),
    .rd_valid_o (line_v),
    .rd_tag_o   (line_tag),
    .rd_data_o  (line_data),
    .wr_i       (wr),
    .wr_idx_i   (wr_idx),
    .wr_tag_i   (wr_tag),
    .wr_data_i  (wr_data)
  );

  assign line_hit = line_v && (line_tag == tlb_ppn);

  oic_ctrl #(.IDX_W(IDX_W), .DISP_W(DISP_W), .PPN_W(PPN_W), .DATA_W(DATA_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .byte_mode_i (byte_mode_i),
    .idx_i       (idx),
    .disp_i      (disp),
    .tlb_hit_i   (tlb_hit),
    .ppn_i       (tlb_ppn),
    .line_hit_i  (line_hit),
    .line_data_i (line_data),
    .wr_o        (wr),
    .wr_idx_o    (wr_idx),
    .wr_tag_o    (wr_tag),
    .wr_data_o   (wr_data),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .tlb_hit_o   (tlb_hit_o),
    .cache_hit_o (cache_hit_o),
    .tlb_miss_o  (tlb_miss_o)
  );
endmodule

// File: rtl/oic_chk.sv
module oic_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        done_o,
  input logic        cache_hit_o,
  input logic        tlb_hit_o,
  input logic        tlb_miss_o,
  input logic        mem_req_o,
  input logic        mem_valid_i,
  input logic [31:0] mem_addr_o
);
  a_r4_hit_needs_xlat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_hit_o |-> (tlb_hit_o && done_o));

  a_r3_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_miss_o |-> (!done_o && !mem_req_o));

  a_r7_fill_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r7_fill_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=> (done_o && !cache_hit_o && !mem_req_o));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind offset_indexed_cache oic_chk i_oic_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .cache_hit_o (cache_hit_o),
  .tlb_hit_o   (tlb_hit_o),
  .tlb_miss_o  (tlb_miss_o),
  .mem_req_o   (mem_req_o),
  .mem_valid_i (mem_valid_i),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/test_offset_indexed_cache.sv
module test_offset_indexed_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] vaddr = '0;
  logic        bmode = 1'b0;
  logic        ld = 1'b0;
  logic [19:0] ld_vpn = '0;
  logic [19:0] ld_ppn = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic        thit, chit, tmiss;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  bit        m_v   [1024];
  bit [19:0] m_tag [1024];
  bit [31:0] m_dat [1024];
  bit        t_v   [8];
  bit [19:0] t_vpn [8];
  bit [19:0] t_ppn [8];
  int        t_ptr;

  always #4 clk = ~clk;

  offset_indexed_cache i_offset_indexed_cache (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(vaddr),
    .byte_mode_i(bmode), .tlb_ld_i(ld), .tlb_ld_vpn_i(ld_vpn),
    .tlb_ld_ppn_i(ld_ppn), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata), .done_o(done),
    .rdata_o(rdata), .tlb_hit_o(thit), .cache_hit_o(chit), .tlb_miss_o(tmiss)
  );

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic bit [31:0] memw(bit [31:0] pa);
    return {pa[15:0] ^ 16'h5A3C, pa[31:16] + 16'h1234};
  endfunction

  function automatic bit [31:0] shape(bit [31:0] w, bit [1:0] d, bit bm);
    bit [31:0] s;
    s = w >> (8 * d);
    return bm ? {24'h0, s[7:0]} : w;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) m_v[i] = 0;
    for (int i = 0; i < 8; i++) t_v[i] = 0;
    t_ptr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    chk("R9", "done in reset", {31'h0, done}, 32'h0);
    chk("R9", "mem_req in reset", {31'h0, mem_req}, 32'h0);
    chk("R9", "tlb_miss in reset", {31'h0, tmiss}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic tlb_load(bit [19:0] v, bit [19:0] p);
    @(negedge clk);
    ld = 1'b1; ld_vpn = v; ld_ppn = p;
    @(negedge clk);
    ld = 1'b0;
    t_v[t_ptr] = 1; t_vpn[t_ptr] = v; t_ppn[t_ptr] = p;
    t_ptr = (t_ptr + 1) % 8;
  endtask

  // one access; the model decides which path is due and every cycle is checked
  task automatic rd(bit [31:0] va, bit bm, int lat, string rq);
    bit        th = 0;
    bit [19:0] pp = '0;
    bit [9:0]  ix;
    bit [31:0] pa, w;
    ix = va[11:2];
    for (int i = 0; i < 8; i++)
      if (t_v[i] && t_vpn[i] == va[31:12]) begin th = 1; pp = t_ppn[i]; end
    @(negedge clk);
    req = 1'b1; vaddr = va; bmode = bm;
    @(negedge clk);
    if (!th) begin
      chk("R3", "tlb_miss", {31'h0, tmiss}, 32'h1);
      chk("R3", "done on xlat miss", {31'h0, done}, 32'h0);
      chk("R3", "mem_req on xlat miss", {31'h0, mem_req}, 32'h0);
      @(negedge clk);
      chk("R3", "still stalled", {30'h0, done, mem_req}, 32'h0);
      req = 1'b0;
      return;
    end
    pa = {pp, ix, 2'b00};
    if (m_v[ix] && m_tag[ix] == pp) begin
      w = m_dat[ix];
      chk("R4", "done on hit", {31'h0, done}, 32'h1);
      chk("R4", "cache_hit/tlb_hit", {30'h0, chit, thit}, 32'h3);
      chk(rq, "hit data", rdata, shape(w, va[1:0], bm));
    end else begin
      w = memw(pa);
      chk("R7", "mem_req raised", {31'h0, mem_req}, 32'h1);
      chk("R1", "fill address", mem_addr, pa);
      chk("R7", "no early done", {31'h0, done}, 32'h0);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk("R7", "mem_req held", {31'h0, mem_req}, 32'h1);
        chk("R7", "address held", mem_addr, pa);
        chk("R7", "no done while waiting", {31'h0, done}, 32'h0);
      end
      mem_valid = 1'b1; mem_rdata = w;
      @(negedge clk);
      mem_valid = 1'b0; mem_rdata = '0;
      chk("R7", "done after fill", {31'h0, done}, 32'h1);
      chk("R7", "cache_hit/tlb_hit after fill", {30'h0, chit, thit}, 32'h1);
      chk(rq, "fill data", rdata, shape(w, va[1:0], bm));
      chk("R7", "mem_req dropped", {31'h0, mem_req}, 32'h0);
      m_v[ix] = 1; m_tag[ix] = pp; m_dat[ix] = w;
    end
    req = 1'b0;
    @(negedge clk);
    chk("R10", "single done pulse", {31'h0, done}, 32'h0);
  endtask

  initial begin
    model_clear();
    do_reset();
    chk("R9", "idle after reset", {29'h0, done, mem_req, tmiss}, 32'h0);

    rd(32'h0001_2344, 0, 0, "R9");           // empty translation buffer
    tlb_load(20'h00012, 20'h00345);
    rd(32'h0001_2344, 0, 2, "R7");           // compulsory fill
    rd(32'h0001_2344, 0, 0, "R4");           // hit
    rd(32'h0001_2345, 1, 0, "R8");           // byte lanes
    rd(32'h0001_2346, 1, 0, "R8");
    rd(32'h0001_2347, 1, 0, "R8");
    rd(32'h0001_2344, 1, 0, "R8");

    tlb_load(20'h00077, 20'h00345);          // alias to same physical page
    rd(32'h0007_7344, 0, 0, "R5");

    tlb_load(20'h00013, 20'h00999);          // same index, other page
    rd(32'h0001_3344, 0, 1, "R6");
    rd(32'h0001_2344, 0, 3, "R6");
    rd(32'h0001_3344, 0, 0, "R6");

    for (int i = 0; i < 6; i++) tlb_load(20'h00100 + 20'(i), 20'h00400 + 20'(i));
    rd(32'h0001_2000, 0, 0, "R2");           // entry 0 evicted by ninth load
    rd(32'h0007_7344, 0, 0, "R2");           // entry 1 kept
    rd(32'h0010_5ABC, 0, 1, "R2");           // newest load in entry 0

    for (int i = 0; i < 40; i++) begin
      bit [31:0] va;
      va = {20'h00100 + 20'(i % 6), 10'((i * 37) % 16), 2'(i)};
      rd(va, i[0], i % 4, "R1");
    end

    do_reset();
    tlb_load(20'h00077, 20'h00345);
    rd(32'h0007_7344, 0, 1, "R9");           // line was valid before reset

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule